// File: doc/BRIEF.md
# Supply Supervisor Reset and Watchdog Controller

This block drives a processor reset line from two digitized supply-status flags and an internal watchdog. It stretches reset after power-up. It forces reset whenever the main supply sits below its trip level. It also forces reset when the watchdog runs out without being serviced. The watchdog is serviced by activity on a serial-bus data line: a low level held long enough, as a bus start condition produces, counts as a service event.

A second supply flag drives its own fail output, which is separate from the reset logic. All timing is counted in clock cycles from parameters, so the same RTL serves a real-time build (around 150 ms periods) and a short-period simulation build. The reset output is forced asserted as soon as the raw main-supply flag goes high, with no clock needed. Every state element is preset by that flag, so the output is already in its safe state while the supply is collapsing.

Top module: `sup_reset_top`

## Requirements
- R1: While `mainLow` is 1, `resetOut` reads 1. After `mainLow` falls, `resetOut` stays 1 and drops to 0 exactly at the RST_CYCLES+2 rising clock edge counted from the first edge after the fall. Two of those edges are synchronizer latency.
- R2: A rise of `mainLow` sets `resetOut` to 1 at once, without waiting for a clock edge. If `mainLow` pulses high during a reset stretch, the stretch starts again from the new fall, with the same timing as R1.
- R3: With no service event, `resetOut` returns to 1 at the WDT_CYCLES-th rising edge after the edge that released it.
- R4: A reset caused by the watchdog keeps `resetOut` at 1 for exactly RST_CYCLES edges, then releases it.
- R5: `sdaIn` is a service event when it is sampled 0 on KICK_LOW consecutive rising edges. The watchdog restarts at the edge that follows those KICK_LOW edges, so expiry moves to WDT_CYCLES edges after that restart edge.
- R6: A low on `sdaIn` that lasts fewer than KICK_LOW sampling edges leaves the watchdog expiry edge unchanged.
- R7: The watchdog is held at zero while `resetOut` is 1, and a service event in that time is discarded. After every release, expiry falls exactly WDT_CYCLES edges later.
- R8: `auxFail` follows `auxLow`, with 1 meaning fail, two rising edges later. It does not change when `resetOut` changes, and `resetOut` does not depend on it.
- R9: While `mainLow` is 1, `auxFail` reads 1. It returns to the value of `auxLow` two edges after `mainLow` falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counting clock |
| mainLow | input | 1 | Main supply below trip (1 = low); also the asynchronous preset of all state |
| auxLow | input | 1 | Second supply below trip (1 = low) |
| sdaIn | input | 1 | Serial-bus data line used to service the watchdog (idle high) |
| resetOut | output | 1 | Processor reset, 1 = asserted |
| auxFail | output | 1 | Second supply fail, 1 = failing |

## Verification
The bench places every reset edge on an exact cycle. A design that is off by one on either the synchronizer depth or the timeout compare releases or expires one cycle early or late, and those checks catch it. It sends a data-line low one cycle shorter than the service threshold. A design that counts the low duration loosely would treat it as a service event and move the expiry. It also holds the data line low during a watchdog reset and pulses the main flag in the middle of a stretch. A design that honours a service event during reset, or that fails to restart the stretch, releases too early. It sets the second supply flag across a watchdog reset, so any coupling between the two outputs shows up as a wrong level.

// File: rtl/sup_pkg.sv
package sup_pkg;
  // strobes from the control FSM to the counter datapath
  typedef struct packed {
    logic clrRst;
    logic incRst;
    logic clrWd;
    logic incWd;
  } supStrobe_t;

  typedef enum logic {
    ST_HOLD = 1'b0,
    ST_RUN  = 1'b1
  } supState_t;
endpackage

// File: rtl/sup_sync.sv
module sup_sync #(
  parameter int STAGES = 2,
  parameter bit PRESET = 1'b1
) (
  input  logic clk,
  input  logic arst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or posedge arst) begin
    if (arst) chain <= {STAGES{PRESET}};
    else      chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/sup_datapath.sv
module sup_datapath
  import sup_pkg::*;
#(
  parameter int RST_CYCLES  = 18_750_000,
  parameter int WDT_CYCLES  = 18_750_000,
  parameter int KICK_LOW    = 125,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       arst,
  input  logic       auxLow,
  input  logic       sdaIn,
  input  supStrobe_t strobe,
  output logic       mainLowS,
  output logic       rstDone,
  output logic       wdExpire,
  output logic       kick,
  output logic       auxFail
);
  localparam int RW = $clog2(RST_CYCLES + 1);
  localparam int WW = $clog2(WDT_CYCLES + 1);
  localparam int KW = $clog2(KICK_LOW + 1);
  localparam logic [RW-1:0] RST_LAST = RW'(RST_CYCLES - 1);
  localparam logic [WW-1:0] WD_LAST  = WW'(WDT_CYCLES - 1);
  localparam logic [KW-1:0] KICK_SAT = KW'(KICK_LOW);

  logic sdaS;
  logic [RW-1:0] rstCnt;
  logic [WW-1:0] wdCnt;
  logic [KW-1:0] lowCnt;

  // main flag: asynchronous assert, synchronized release
  sup_sync #(.STAGES(SYNC_STAGES), .PRESET(1'b1)) u_mainSync (
    .clk(clk), .arst(arst), .d(1'b0), .q(mainLowS));
  // aux flag reads as failing while the main supply is down
  sup_sync #(.STAGES(SYNC_STAGES), .PRESET(1'b1)) u_auxSync (
    .clk(clk), .arst(arst), .d(auxLow), .q(auxFail));
  // data line idles high
  sup_sync #(.STAGES(SYNC_STAGES), .PRESET(1'b1)) u_sdaSync (
    .clk(clk), .arst(arst), .d(sdaIn), .q(sdaS));

  always_ff @(posedge clk or posedge arst) begin
    if (arst)               rstCnt <= '0;
    else if (strobe.clrRst) rstCnt <= '0;
    else if (strobe.incRst) rstCnt <= rstCnt + RW'(1);
  end

  always_ff @(posedge clk or posedge arst) begin
    if (arst)              wdCnt <= '0;
    else if (strobe.clrWd) wdCnt <= '0;
    else if (strobe.incWd) wdCnt <= wdCnt + WW'(1);
  end

  // consecutive-low counter, saturates so one low stretch gives one kick
  always_ff @(posedge clk or posedge arst) begin
    if (arst)                    lowCnt <= '0;
    else if (sdaS)               lowCnt <= '0;
    else if (lowCnt != KICK_SAT) lowCnt <= lowCnt + KW'(1);
  end

  assign rstDone  = (rstCnt == RST_LAST);
  assign wdExpire = (wdCnt == WD_LAST);
  assign kick     = !sdaS && (lowCnt == KICK_SAT - KW'(1));

  assert_kick_single_R5: assert property (@(posedge clk) disable iff (arst)
    kick |=> !kick);
  assert_kick_saturates_R6: assert property (@(posedge clk) disable iff (arst)
    kick |=> (lowCnt == KICK_SAT));
  assert_wd_bound_R3: assert property (@(posedge clk) disable iff (arst)
    wdCnt <= WD_LAST);
endmodule

// File: rtl/sup_ctrl.sv
module sup_ctrl
  import sup_pkg::*;
(
  input  logic       clk,
  input  logic       arst,
  input  logic       mainLowS,
  input  logic       rstDone,
  input  logic       wdExpire,
  input  logic       kick,
  output supStrobe_t strobe,
  output logic       resetOut
);
  supState_t state, stateNext;

  always_ff @(posedge clk or posedge arst) begin
    if (arst) state <= ST_HOLD;
    else      state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strobe    = '0;
    unique case (state)
      ST_HOLD: begin
        strobe.clrWd = 1'b1;            // watchdog frozen at zero in reset
        if (mainLowS)     strobe.clrRst = 1'b1;
        else if (rstDone) stateNext = ST_RUN;
        else              strobe.incRst = 1'b1;
      end
      ST_RUN: begin
        if (mainLowS) begin
          stateNext     = ST_HOLD;
          strobe.clrRst = 1'b1;
        end else if (kick) begin
          strobe.clrWd = 1'b1;
        end else if (wdExpire) begin
          stateNext     = ST_HOLD;
          strobe.clrRst = 1'b1;
        end else begin
          strobe.incWd = 1'b1;
        end
      end
      default: stateNext = ST_HOLD;
    endcase
  end

  assign resetOut = (state == ST_HOLD);

  assert_low_main_resets_R2: assert property (@(posedge clk) disable iff (arst)
    mainLowS |=> resetOut);
  assert_release_after_timeout_R1: assert property (@(posedge clk) disable iff (arst)
    $fell(resetOut) |-> $past(rstDone));
  assert_expiry_resets_R3: assert property (@(posedge clk) disable iff (arst)
    (!resetOut && wdExpire && !kick && !mainLowS) |=> resetOut);
endmodule

// File: rtl/sup_reset_top.sv
module sup_reset_top #(
  parameter int RST_CYCLES  = 18_750_000,
  parameter int WDT_CYCLES  = 18_750_000,
  parameter int KICK_LOW    = 125,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic mainLow,
  input  logic auxLow,
  input  logic sdaIn,
  output logic resetOut,
  output logic auxFail
);
  sup_pkg::supStrobe_t strobe;
  logic mainLowS, rstDone, wdExpire, kick;

  sup_datapath #(
    .RST_CYCLES(RST_CYCLES), .WDT_CYCLES(WDT_CYCLES),
    .KICK_LOW(KICK_LOW), .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk(clk), .arst(mainLow), .auxLow(auxLow), .sdaIn(sdaIn),
    .strobe(strobe), .mainLowS(mainLowS), .rstDone(rstDone),
    .wdExpire(wdExpire), .kick(kick), .auxFail(auxFail));

  sup_ctrl u_ctrl (
    .clk(clk), .arst(mainLow), .mainLowS(mainLowS), .rstDone(rstDone),
    .wdExpire(wdExpire), .kick(kick), .strobe(strobe), .resetOut(resetOut));
endmodule

// File: tb/sim_sup_reset_top.sv
module sim_sup_reset_top;
  localparam int RSTC = 20;
  localparam int WDTC = 40;
  localparam int KLOW = 4;
  localparam int NV   = 35;

  // vector: [16] mainLow [15] auxLow [14] sdaIn [13:6] edges to wait
  //         [5] expected resetOut [4] expected auxFail [3:0] requirement number
  localparam logic [16:0] VEC [0:NV-1] = '{
    {1'b0,1'b0,1'b1, 8'(RSTC+1), 1'b1,1'b0, 4'd1},  // R1 still in stretch
    {1'b0,1'b0,1'b1, 8'd1,       1'b0,1'b0, 4'd1},  // R1 release edge
    {1'b0,1'b0,1'b1, 8'(WDTC-1), 1'b0,1'b0, 4'd3},  // R3 just before expiry
    {1'b0,1'b0,1'b1, 8'd1,       1'b1,1'b0, 4'd3},  // R3 expiry edge
    {1'b0,1'b0,1'b1, 8'(RSTC-1), 1'b1,1'b0, 4'd4},  // R4
    {1'b0,1'b0,1'b1, 8'd1,       1'b0,1'b0, 4'd4},  // R4
    {1'b0,1'b0,1'b1, 8'd10,      1'b0,1'b0, 4'd5},  // R5
    {1'b0,1'b0,1'b0, 8'(KLOW),   1'b0,1'b0, 4'd5},  // R5 service low
    {1'b0,1'b0,1'b1, 8'd41,      1'b0,1'b0, 4'd5},  // R5 past unserviced expiry
    {1'b0,1'b0,1'b1, 8'd1,       1'b1,1'b0, 4'd5},  // R5 shifted expiry
    {1'b0,1'b0,1'b1, 8'(RSTC-1), 1'b1,1'b0, 4'd4},  // R4
    {1'b0,1'b0,1'b1, 8'd1,       1'b0,1'b0, 4'd4},  // R4
    {1'b0,1'b0,1'b1, 8'd5,       1'b0,1'b0, 4'd6},  // R6
    {1'b0,1'b0,1'b0, 8'(KLOW-1), 1'b0,1'b0, 4'd6},  // R6 short low
    {1'b0,1'b0,1'b1, 8'd31,      1'b0,1'b0, 4'd6},  // R6
    {1'b0,1'b0,1'b1, 8'd1,       1'b1,1'b0, 4'd6},  // R6 expiry unchanged
    {1'b0,1'b0,1'b0, 8'd6,       1'b1,1'b0, 4'd7},  // R7 low during reset
    {1'b0,1'b0,1'b1, 8'd13,      1'b1,1'b0, 4'd7},  // R7
    {1'b0,1'b0,1'b1, 8'd1,       1'b0,1'b0, 4'd7},  // R7 release
    {1'b0,1'b0,1'b1, 8'(WDTC-1), 1'b0,1'b0, 4'd7},  // R7 no credit kept
    {1'b0,1'b0,1'b1, 8'd1,       1'b1,1'b0, 4'd7},  // R7
    {1'b0,1'b0,1'b1, 8'(RSTC),   1'b0,1'b0, 4'd4},  // R4
    {1'b0,1'b1,1'b1, 8'd1,       1'b0,1'b0, 4'd8},  // R8 latency
    {1'b0,1'b1,1'b1, 8'd1,       1'b0,1'b1, 4'd8},  // R8
    {1'b0,1'b0,1'b1, 8'd1,       1'b0,1'b1, 4'd8},  // R8
    {1'b0,1'b0,1'b1, 8'd1,       1'b0,1'b0, 4'd8},  // R8
    {1'b0,1'b1,1'b1, 8'd35,      1'b0,1'b1, 4'd8},  // R8
    {1'b0,1'b1,1'b1, 8'd1,       1'b1,1'b1, 4'd8},  // R8 across watchdog reset
    {1'b0,1'b0,1'b1, 8'd2,       1'b1,1'b0, 4'd8},  // R8
    {1'b0,1'b0,1'b1, 8'(RSTC-2), 1'b0,1'b0, 4'd4},  // R4
    {1'b1,1'b0,1'b1, 8'd3,       1'b1,1'b1, 4'd9},  // R9
    {1'b0,1'b0,1'b1, 8'd10,      1'b1,1'b0, 4'd2},  // R2 partial stretch
    {1'b1,1'b0,1'b1, 8'd1,       1'b1,1'b1, 4'd2},  // R2 glitch
    {1'b0,1'b0,1'b1, 8'(RSTC+1), 1'b1,1'b0, 4'd2},  // R2 restarted stretch
    {1'b0,1'b0,1'b1, 8'd1,       1'b0,1'b0, 4'd2}   // R2
  };

  logic clk = 1'b0;
  logic mainLow = 1'b0;
  logic auxLow = 1'b0;
  logic sdaIn = 1'b1;
  logic resetOut, auxFail;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  sup_reset_top #(.RST_CYCLES(RSTC), .WDT_CYCLES(WDTC), .KICK_LOW(KLOW)) u0 (
    .clk(clk), .mainLow(mainLow), .auxLow(auxLow), .sdaIn(sdaIn),
    .resetOut(resetOut), .auxFail(auxFail));

  task automatic check(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  initial begin
    #1 mainLow = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", "resetOut at power-up", resetOut, 1'b1);
    check("R9", "auxFail while main low", auxFail, 1'b1);
    for (int i = 0; i < NV; i++) begin
      mainLow = VEC[i][16];
      auxLow  = VEC[i][15];
      sdaIn   = VEC[i][14];
      repeat (int'(VEC[i][13:6])) @(negedge clk);
      check($sformatf("R%0d", VEC[i][3:0]), $sformatf("vec%0d resetOut", i), resetOut, VEC[i][5]);
      check($sformatf("R%0d", VEC[i][3:0]), $sformatf("vec%0d auxFail", i), auxFail, VEC[i][4]);
    end
    // R2: assertion with no clock edge in between
    repeat (5) @(negedge clk);
    mainLow = 1'b1;
    #1 check("R2", "asynchronous assert", resetOut, 1'b1);
    @(negedge clk);
    mainLow = 1'b0;
    repeat (RSTC + 2) @(negedge clk);
    check("R1", "release after main recovery", resetOut, 1'b0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog run did not complete actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule